// File: doc/BRIEF.md
# Debounced Differential Clock Stop Controller

This block distributes one input clock to a group of differential outputs and can halt a chosen subset of them on request. The stop request is an active-low level that may change at any time relative to the clock. It is synchronized and debounced on the falling edges of the input clock, which are the rising edges of the complement outputs. A request level is accepted only after it has held steady on two consecutive sampling edges.

Each output pair is either free-running or stoppable, as set by a per-output mask. Stoppable pairs halt on a rising input-clock edge, where the true output has just gone high. A single control bit selects how a halted pair parks. It can stay driven, with the true output high and the complement low. It can instead be released to high impedance, which is modelled here as a low output-enable with both levels reading low. When the request is withdrawn, all halted pairs restart on the same rising edge, and the first high phase has full width. The mask and the park-mode bit are captured only while no stop is in effect.

Top module: `diff_clk_stop`

## Requirements
- R1: The request input `stop_req_n` is sampled on falling edges of `clk_in`. During and directly after reset, every pair runs free: `out_oe` is all ones, `out_p` follows `clk_in` and `out_n` is its inverse.
- R2: A new request level is accepted at a falling edge only if the same level was sampled on two consecutive earlier falling edges. A low level seen on only one falling edge has no effect on any output.
- R3: A stop that is held halts the stoppable pairs on the rising edge of `clk_in` that comes 3.5 clock periods after the first falling edge that sampled the low level.
- R4: With `park_float`=0, a halted pair outputs `out_p`=1, `out_n`=0 and `out_oe`=1.
- R5: With `park_float`=1, a halted pair outputs `out_oe`=0 and `out_p`=`out_n`=0.
- R6: A pair whose `stoppable` bit is 0 ignores the request: it keeps toggling with `out_oe`=1.
- R7: After a release, every halted pair resumes on the rising edge of `clk_in` that comes 3.5 periods after the first falling edge that sampled the high level. All pairs resume on that same edge. This latency lies inside the allowed window of 2 to 6 periods.
- R8: With `park_float`=1, `out_oe` returns to 1 at the resume edge, and `out_p` is high at that point.
- R9: `stoppable` and `park_float` are captured on rising edges only while no stop is accepted and no pair is halted. Changes made during a stop take effect only after the outputs have resumed.
- R10: While `out_oe` is 1, no high pulse on `out_p` or `out_n` is shorter than half a clock period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Input clock that is copied to all pairs |
| rst_n | input | 1 | Asynchronous active-low reset |
| stop_req_n | input | 1 | Asynchronous active-low stop request |
| stoppable | input | NUM_OUT | Per pair: 1 means stoppable, 0 means free-running |
| park_float | input | 1 | Park mode: 0 means driven high/low, 1 means undriven |
| out_p | output | NUM_OUT | True outputs |
| out_n | output | NUM_OUT | Complement outputs |
| out_oe | output | NUM_OUT | Per-pair output enable |

## Verification
The request passes through three falling-edge stages and one rising-edge stage. As a result, both a halt and a resume are due exactly 17.5 ns (3.5 periods) after the first falling edge that samples the new level. In driven mode, the first visible effect of a resume is the falling edge of `out_p`, which is due 20 ns after that sampling edge. The bench changes the request 1 ns after a rising edge, so exactly one known falling edge samples each change. It measures these latencies against those instants. A behavioural model follows the sampled history of the request, and its predictions are compared with every output 1 ns after each clock edge. This keeps all comparisons clear of the edges where the outputs switch. Pulse widths are measured edge to edge on every enabled output.

// File: rtl/diff_clk_stop.sv
module diff_clk_stop #(
  parameter int NUM_OUT = 8
) (
  input  logic               clk_in,
  input  logic               rst_n,
  input  logic               stop_req_n,
  input  logic [NUM_OUT-1:0] stoppable,
  input  logic               park_float,
  output logic [NUM_OUT-1:0] out_p,
  output logic [NUM_OUT-1:0] out_n,
  output logic [NUM_OUT-1:0] out_oe
);

  logic sync1, sync2, sync3;
  logic stop_valid;
  logic halted;
  logic [NUM_OUT-1:0] mask_q;
  logic park_q;

  always_ff @(negedge clk_in or negedge rst_n) begin
    if (!rst_n) begin
      sync1      <= 1'b1;
      sync2      <= 1'b1;
      sync3      <= 1'b1;
      stop_valid <= 1'b0;
    end else begin
      sync1 <= stop_req_n;
      sync2 <= sync1;
      sync3 <= sync2;
      if (sync2 == sync3) stop_valid <= ~sync2;
    end
  end

  always_ff @(posedge clk_in or negedge rst_n) begin
    if (!rst_n) begin
      halted <= 1'b0;
      mask_q <= '0;
      park_q <= 1'b0;
    end else begin
      halted <= stop_valid;
      if (!stop_valid && !halted) begin
        mask_q <= stoppable;
        park_q <= park_float;
      end
    end
  end

  for (genvar g = 0; g < NUM_OUT; g++) begin : g_pair
    logic run;
    assign run       = ~(halted & mask_q[g]);
    assign out_p[g]  = run ? clk_in  : ~park_q;
    assign out_n[g]  = run ? ~clk_in : 1'b0;
    assign out_oe[g] = run | ~park_q;
  end

  // R2
  debounce_two_edge_chk: assert property (@(negedge clk_in) disable iff (!rst_n)
    $rose(stop_valid) |-> $past(!sync2 && !sync3));

  // R3
  halt_follows_valid_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
    $rose(halted) |-> $past(stop_valid));

  // R9
  cfg_frozen_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
    halted |=> ($stable(mask_q) && $stable(park_q)));

  // R5
  float_park_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
    (halted && park_q) |-> ((out_oe & mask_q) == '0));

  // R6
  free_run_oe_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
    (out_oe | mask_q) == {NUM_OUT{1'b1}});

endmodule

// File: tb/test_diff_clk_stop.sv
`timescale 1ns/1ps
module test_diff_clk_stop;
  localparam int N = 8;

  logic clk_in = 1'b0;
  logic rst_n = 1'b0;
  logic stop_req_n = 1'b1;
  logic [N-1:0] stoppable = '0;
  logic park_float = 1'b0;
  logic [N-1:0] out_p, out_n, out_oe;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  diff_clk_stop #(.NUM_OUT(N)) i_diff_clk_stop (
    .clk_in(clk_in), .rst_n(rst_n), .stop_req_n(stop_req_n),
    .stoppable(stoppable), .park_float(park_float),
    .out_p(out_p), .out_n(out_n), .out_oe(out_oe)
  );

  always #2.5 clk_in = ~clk_in;

  // behavioural reference model
  bit h0 = 1, h1 = 1, h2 = 1;
  bit ev = 0, eh = 0, emode = 0;
  logic [N-1:0] emask = '0;

  always @(negedge clk_in or negedge rst_n) begin
    if (!rst_n) begin
      h0 = 1; h1 = 1; h2 = 1; ev = 0;
    end else begin
      if (h1 == h2) ev = !h1;
      h2 = h1; h1 = h0; h0 = stop_req_n;
    end
  end

  always @(posedge clk_in or negedge rst_n) begin
    if (!rst_n) begin
      eh = 0; emask = '0; emode = 0;
    end else begin
      bit upd;
      upd = !ev && !eh;
      eh = ev;
      if (upd) begin emask = stoppable; emode = park_float; end
    end
  end

  always @(clk_in) begin
    #1;
    if (!done) begin
      logic [N-1:0] xp, xn, xoe;
      for (int i = 0; i < N; i++) begin
        if (!(eh && emask[i])) begin
          xp[i] = clk_in; xn[i] = !clk_in; xoe[i] = 1'b1;
        end else begin
          xp[i] = !emode; xn[i] = 1'b0; xoe[i] = !emode;
        end
      end
      checks++;
      if (out_p !== xp || out_n !== xn || out_oe !== xoe) begin
        errors++;
        $display("FAIL model R1 R2 R3 R4 R5 R6 R7 R8 R9 t=%0t p=%h/%h n=%h/%h oe=%h/%h (actual/expected)",
                 $time, out_p, xp, out_n, xn, out_oe, xoe);
      end
    end
  end

  // R10 pulse width monitor
  for (genvar g = 0; g < N; g++) begin : mon
    real tp = 0.0, tn = 0.0;
    always @(posedge out_p[g]) tp = $realtime;
    always @(posedge out_n[g]) tn = $realtime;
    always @(negedge out_p[g]) begin
      real w;
      w = $realtime - tp;
      #0.01;
      if (out_oe[g] && rst_n && !done) begin
        checks++;
        if (w < 2.49) begin
          errors++;
          $display("FAIL R10 out_p[%0d] high width %0.3f expected >= 2.5", g, w);
        end
      end
    end
    always @(negedge out_n[g]) begin
      real w;
      w = $realtime - tn;
      #0.01;
      if (out_oe[g] && rst_n && !done && tn > 0.0) begin
        checks++;
        if (w < 2.49) begin
          errors++;
          $display("FAIL R10 out_n[%0d] high width %0.3f expected >= 2.5", g, w);
        end
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic check_lat(input real lat, input real exp, input string tag);
    checks++;
    if (lat < exp - 0.01 || lat > exp + 0.01) begin
      errors++;
      $display("FAIL %s latency actual=%0.3f expected=%0.3f", tag, lat, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(posedge clk_in);
  endtask

  task automatic set_req(input bit v, output real tsamp);
    @(posedge clk_in); #1;
    stop_req_n = v;
    @(negedge clk_in);
    tsamp = $realtime;
  endtask

  initial begin
    real ts, lat;
    #12;
    check(out_oe === 8'hFF, "R1 reset oe", int'(out_oe), 255);
    #9 rst_n = 1'b1;
    cycles(4);
    check(out_oe === 8'hFF, "R1 after reset oe", int'(out_oe), 255);

    stoppable = 8'hAA; park_float = 1'b0;
    cycles(4);

    // R2: one-edge low pulse is ignored
    @(posedge clk_in); #1 stop_req_n = 1'b0;
    @(posedge clk_in); #1 stop_req_n = 1'b1;
    repeat (6) begin
      @(posedge clk_in); #1;
      check(out_n[1] === 1'b0 && out_p[1] === 1'b1, "R2 glitch high phase", int'(out_p[1]), 1);
      @(negedge clk_in); #1;
      check(out_n[1] === 1'b1 && out_oe[1] === 1'b1, "R2 glitch low phase", int'(out_n[1]), 1);
    end

    // driven park, mask AA
    set_req(1'b0, ts);
    cycles(6); #1;
    check(out_p[1] === 1'b1 && out_n[1] === 1'b0 && out_oe[1] === 1'b1, "R4 parked level", int'(out_n[1]), 0);
    check(out_oe[0] === 1'b1, "R6 free oe", int'(out_oe[0]), 1);
    @(negedge clk_in); #1;
    check(out_n[0] === 1'b1 && out_p[0] === 1'b0, "R6 free toggles", int'(out_n[0]), 1);
    check(out_p[3] === 1'b1 && out_p[5] === 1'b1, "R4 parked during low phase", int'(out_p[3]), 1);
    cycles(10);
    set_req(1'b1, ts);
    @(negedge out_p[1]);
    lat = $realtime - ts;
    check_lat(lat, 20.0, "R7 driven resume first fall");
    check(out_p === 8'h00, "R7 all pairs together", int'(out_p), 0);
    cycles(6);

    // undriven park, mask F0
    stoppable = 8'hF0; park_float = 1'b1;
    cycles(4);
    set_req(1'b0, ts);
    @(negedge out_oe[7]);
    lat = $realtime - ts;
    check_lat(lat, 17.5, "R3 halt latency");
    #0.1;
    check(out_oe === 8'h0F, "R5 oe", int'(out_oe), 15);
    check((out_p & 8'hF0) === 8'h00 && (out_n & 8'hF0) === 8'h00, "R5 levels", int'(out_p & 8'hF0), 0);

    // R9: changes during stop ignored
    stoppable = 8'h0F; park_float = 1'b0;
    cycles(8); #1;
    check(out_oe === 8'h0F, "R9 cfg ignored while halted", int'(out_oe), 15);
    check((out_p & 8'h0F) === 8'h0F, "R9 low nibble free", int'(out_p), 15);
    set_req(1'b1, ts);
    @(posedge out_oe[4]);
    lat = $realtime - ts;
    check_lat(lat, 17.5, "R7 undriven resume");
    #0.1;
    check(out_p[4] === 1'b1 && out_oe === 8'hFF, "R8 resume driven high", int'(out_p[4]), 1);
    cycles(4);

    // new config now in effect: mask 0F driven
    set_req(1'b0, ts);
    cycles(6);
    @(negedge clk_in); #1;
    check(out_p[0] === 1'b1 && out_n[0] === 1'b0 && out_oe[0] === 1'b1, "R9 new mask applied", int'(out_p[0]), 1);
    check(out_n[7] === 1'b1, "R6 upper nibble free", int'(out_n[7]), 1);
    set_req(1'b1, ts);
    cycles(8);

    // all stoppable
    stoppable = 8'hFF;
    cycles(3);
    set_req(1'b0, ts);
    cycles(8);
    @(negedge clk_in); #1;
    check(out_p === 8'hFF && out_n === 8'h00, "R4 all parked", int'(out_p), 255);
    set_req(1'b1, ts);
    @(negedge out_p[2]);
    lat = $realtime - ts;
    check_lat(lat, 20.0, "R7 all resume");
    cycles(6);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule